// File: doc/BRIEF.md
# Dot-Inversion Line Load and Gamma Segment Selector

This block sits between a source driver's line latch and its analog output stage. When the load strobe rises, it copies the current line-latch contents into an output holding register. On the same edge it samples a polarity select bit. Together these set the dot-inversion pattern for the line that is now on display. Between loads, both the held line and the held polarity stay fixed, whatever the latch and the polarity pin do.

For every channel, the block decodes the held 6-bit gray code into the controls that an analog resistor ladder can use directly:
- a positive/negative flag;
- the index of the 16-code segment the code falls in;
- the two gamma reference indices that bound that segment, given in the order the code walks them;
- a 4-bit step within the segment;
- a flag raised when the step lands exactly on the far reference.

Positive channels walk references 1 up to 5. Negative channels walk a mirrored chain from 10 down to 6.

Top module: `dotinv_gamma_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, the holding register clears to all-zero codes and the held polarity clears to 0. After that edge, channel 1 therefore reads as positive with segment 0 and step 0.
- R2: The load strobe is sampled on `clk`. At the first clock edge where `ld_strobe` is 1 after being 0 at the previous edge, `line_bus` and `pol_sel` are captured. A strobe already high at the first edge after reset also counts as a rise. The new values show on the outputs right after that edge.
- R3: At every edge without a strobe rise, the held codes keep their values. This holds even while the strobe stays high and `line_bus` changes.
- R4: `pol_sel` has no effect except at a strobe rise.
- R5: Channel k, numbered from 1, is held at `line_bus[(k-1)*6 +: 6]`. Its polarity flag `ch_pos` bit k-1 (1 = positive) is set as follows. If the held polarity is 1, even k is positive and odd k is negative. If the held polarity is 0, the assignment is the reverse.
- R6: For a positive channel with code c, the segment is c[5:4]. `ch_ref_a` (the start reference) is segment+1, and `ch_ref_b` (the end reference) is segment+2. So code 00h starts at reference 1, and codes 30h–3Fh end at reference 5.
- R7: For a negative channel, the segment is also c[5:4]. `ch_ref_a` is 10−segment and `ch_ref_b` is 9−segment. So code 00h starts at reference 10, and codes 30h–3Fh end at reference 6.
- R8: The step `ch_step` equals c[3:0] for both polarities.
- R9: `ch_edge` is 1 exactly when c[3:0] = 1111b. This covers 0Fh, 1Fh, 2Fh and 3Fh, and marks that the voltage equals the end reference.
- R10: Loads on alternate cycles each take effect. A partly rewritten line latch is transferred exactly as it stands at the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_strobe | input | 1 | Line load strobe, acted on at its rising edge |
| pol_sel | input | 1 | Dot-inversion polarity select |
| line_bus | input | NCH*6 | Line-latch contents, channel 1 in the low bits |
| ch_pos | output | NCH | Per-channel polarity, 1 = positive |
| ch_seg | output | NCH*2 | Per-channel segment index |
| ch_step | output | NCH*4 | Per-channel step within segment |
| ch_edge | output | NCH | Per-channel end-reference-exact flag |
| ch_ref_a | output | NCH*4 | Per-channel start reference index (1..10) |
| ch_ref_b | output | NCH*4 | Per-channel end reference index (1..10) |

## Verification
A strobe rise can coincide with a change on both `pol_sel` and `line_bus`. The held values must then be the ones present at that edge. A strobe held high can also overlap with further bus and polarity changes, which must then be ignored. The bench provokes both cases: it changes all three inputs together in one cycle, and it keeps the strobe high for several cycles while the bus and polarity keep moving. A behavioural model judges every channel's six output fields after every edge.

// File: rtl/dotinv_gamma_pkg.sv
// Shared constants for the dot-inversion load and gamma segment selector.
// Assumes a 6-bit gray code split as a 2-bit segment over a 4-bit step.
package dotinv_gamma_pkg;
    localparam int CODE_W = 6;
    localparam int STEP_W = 4;
    localparam int SEG_W  = CODE_W - STEP_W;
    localparam int NSEG   = 1 << SEG_W;
    // References per polarity chain: one more than the number of segments.
    localparam int REFS_PER_CHAIN = NSEG + 1;
    localparam int NREF   = 2 * REFS_PER_CHAIN;
    localparam int REF_W  = $clog2(NREF + 1);
    localparam logic [REF_W-1:0] POS_FIRST_REF = REF_W'(1);
    localparam logic [REF_W-1:0] NEG_FIRST_REF = REF_W'(NREF);
endpackage

// File: rtl/line_load_capture.sv
// Line load capture: detects the rising edge of the load strobe on clk and,
// on that edge, copies the line bus into the holding register and samples the
// polarity select. Assumes the strobe and polarity are synchronous to clk.
module line_load_capture #(
    parameter int NCH    = 12,
    parameter int CODE_W = 6,
    localparam int BUS_W = NCH * CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_strobe,
    input  logic             pol_sel,
    input  logic [BUS_W-1:0] line_bus,
    output logic [BUS_W-1:0] held_line,
    output logic             held_pol
);
    logic ld_q;
    logic ld_rise;

    // Rise of the strobe relative to its value at the previous edge.
    assign ld_rise = ld_strobe & ~ld_q;

    // Track the strobe level of the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) ld_q <= 1'b0;
        else        ld_q <= ld_strobe;
    end

    // Capture the line and polarity on a strobe rise, keep them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_line <= '0;
            held_pol  <= 1'b0;
        end else if (ld_rise) begin
            held_line <= line_bus;
            held_pol  <= pol_sel;
        end
    end

    // R2
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rise |=> (held_line == $past(line_bus)) && (held_pol == $past(pol_sel)));
    // R3
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_rise |=> $stable(held_line));
    // R4
    pol_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_rise |=> $stable(held_pol));
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (held_line == '0) && !held_pol);
endmodule

// File: rtl/dot_pol_map.sv
// Dot-inversion polarity map: from the held polarity bit, gives each channel
// its polarity. Channels are numbered from 1; index i is channel i+1.
// With held polarity 1, even-numbered channels are positive.
module dot_pol_map #(
    parameter int NCH = 12
) (
    input  logic           held_pol,
    output logic [NCH-1:0] pos
);
    for (genvar i = 0; i < NCH; i++) begin : g_pol
        // Index i odd means channel i+1 is even.
        localparam bit CH_EVEN = (i % 2) == 1;
        // Assign positive polarity by channel parity and held select.
        always_comb pos[i] = CH_EVEN ? held_pol : ~held_pol;
    end
endmodule

// File: rtl/gamma_chan_decode.sv
// Per-channel gamma decode: splits a held code into segment and step, and
// names the bounding references. The positive chain rises 1..5 and the
// negative chain runs 10..6. Purely combinational.
module gamma_chan_decode
    import dotinv_gamma_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              is_pos,
    output logic [SEG_W-1:0]  seg,
    output logic [STEP_W-1:0] step,
    output logic              at_end,
    output logic [REF_W-1:0]  ref_a,
    output logic [REF_W-1:0]  ref_b
);
    logic [REF_W-1:0] seg_r;

    // Split the code into segment and step fields.
    always_comb begin
        seg    = code[CODE_W-1 -: SEG_W];
        step   = code[STEP_W-1:0];
        at_end = &code[STEP_W-1:0];
        seg_r  = REF_W'(seg);
    end

    // Pick start and end references along the chain for this polarity.
    always_comb begin
        if (is_pos) begin
            ref_a = POS_FIRST_REF + seg_r;
            ref_b = POS_FIRST_REF + seg_r + REF_W'(1);
        end else begin
            ref_a = NEG_FIRST_REF - seg_r;
            ref_b = NEG_FIRST_REF - seg_r - REF_W'(1);
        end
    end
endmodule

// File: rtl/dotinv_gamma_sel.sv
// Top: dot-inversion line load and gamma segment selector. On a strobe rise
// the line latch and polarity are held. Each channel's held code is then
// decoded into polarity, segment, step, end flag and reference indices.
// Assumes all inputs are synchronous to clk.
module dotinv_gamma_sel
    import dotinv_gamma_pkg::*;
#(
    parameter int NCH = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_strobe,
    input  logic                  pol_sel,
    input  logic [NCH*CODE_W-1:0] line_bus,
    output logic [NCH-1:0]        ch_pos,
    output logic [NCH*SEG_W-1:0]  ch_seg,
    output logic [NCH*STEP_W-1:0] ch_step,
    output logic [NCH-1:0]        ch_edge,
    output logic [NCH*REF_W-1:0]  ch_ref_a,
    output logic [NCH*REF_W-1:0]  ch_ref_b
);
    logic [NCH*CODE_W-1:0] held_line;
    logic                  held_pol;

    line_load_capture #(.NCH(NCH), .CODE_W(CODE_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_strobe (ld_strobe),
        .pol_sel   (pol_sel),
        .line_bus  (line_bus),
        .held_line (held_line),
        .held_pol  (held_pol)
    );

    dot_pol_map #(.NCH(NCH)) u_pol (
        .held_pol (held_pol),
        .pos      (ch_pos)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        gamma_chan_decode u_dec (
            .code   (held_line[i*CODE_W +: CODE_W]),
            .is_pos (ch_pos[i]),
            .seg    (ch_seg[i*SEG_W +: SEG_W]),
            .step   (ch_step[i*STEP_W +: STEP_W]),
            .at_end (ch_edge[i]),
            .ref_a  (ch_ref_a[i*REF_W +: REF_W]),
            .ref_b  (ch_ref_b[i*REF_W +: REF_W])
        );

        // R6
        pos_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_pos[i] |-> (ch_ref_b[i*REF_W +: REF_W] == ch_ref_a[i*REF_W +: REF_W] + REF_W'(1))
                       && (ch_ref_a[i*REF_W +: REF_W] >= REF_W'(1))
                       && (ch_ref_b[i*REF_W +: REF_W] <= REF_W'(REFS_PER_CHAIN)));
        // R7
        neg_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_pos[i] |-> (ch_ref_a[i*REF_W +: REF_W] == ch_ref_b[i*REF_W +: REF_W] + REF_W'(1))
                        && (ch_ref_b[i*REF_W +: REF_W] > REF_W'(REFS_PER_CHAIN))
                        && (ch_ref_a[i*REF_W +: REF_W] <= REF_W'(NREF)));
        // R9
        end_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_edge[i] |-> (ch_step[i*STEP_W +: STEP_W] == {STEP_W{1'b1}}));

        if (i > 0) begin : g_par
            // R5
            dot_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ch_pos[i] != ch_pos[i-1]);
        end
    end
endmodule

// File: tb/sim_dotinv_gamma_sel.sv
module sim_dotinv_gamma_sel;
    localparam int NCH = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_strobe = 1'b0;
    logic              pol_sel = 1'b0;
    logic [NCH*6-1:0]  line_bus = '0;
    logic [NCH-1:0]    ch_pos;
    logic [NCH*2-1:0]  ch_seg;
    logic [NCH*4-1:0]  ch_step;
    logic [NCH-1:0]    ch_edge;
    logic [NCH*4-1:0]  ch_ref_a;
    logic [NCH*4-1:0]  ch_ref_b;

    int checks = 0;
    int errors = 0;
    bit check_en = 1'b0;
    bit done = 1'b0;
    string phase = "R1";

    // Behavioural model state
    int  m_code [NCH];
    int  m_pol = 0;
    bit  m_ld_prev = 1'b0;

    dotinv_gamma_sel #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_strobe(ld_strobe), .pol_sel(pol_sel),
        .line_bus(line_bus), .ch_pos(ch_pos), .ch_seg(ch_seg), .ch_step(ch_step),
        .ch_edge(ch_edge), .ch_ref_a(ch_ref_a), .ch_ref_b(ch_ref_b)
    );

    always #5 clk = ~clk;

    // Model update per R1, R2, R3, R4
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) m_code[i] <= 0;
            m_pol <= 0;
            m_ld_prev <= 1'b0;
        end else begin
            if (ld_strobe && !m_ld_prev) begin
                for (int i = 0; i < NCH; i++) m_code[i] <= int'(line_bus[i*6 +: 6]);
                m_pol <= int'(pol_sel);
            end
            m_ld_prev <= ld_strobe;
        end
    end

    task automatic cmp(input int act, input int exp, input string req, input int ch);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s] channel %0d: actual %0d expected %0d", req, phase, ch + 1, act, exp);
        end
    endtask

    // Compare every channel away from the active edge
    always @(negedge clk) begin
        if (check_en) begin
            for (int i = 0; i < NCH; i++) begin
                int c, seg, step, pos, ra, rb;
                c    = m_code[i];
                seg  = c / 16;
                step = c % 16;
                // channel i+1 even when i is odd (R5)
                pos  = (m_pol == 1) ? (i % 2) : 1 - (i % 2);
                ra   = pos ? seg + 1 : 10 - seg;
                rb   = pos ? seg + 2 : 9 - seg;
                cmp(int'(ch_pos[i]), pos, "R5", i);
                cmp(int'(ch_seg[i*2 +: 2]), seg, "R2", i);
                cmp(int'(ch_step[i*4 +: 4]), step, "R8", i);
                cmp(int'(ch_edge[i]), (step == 15) ? 1 : 0, "R9", i);
                cmp(int'(ch_ref_a[i*4 +: 4]), ra, pos ? "R6" : "R7", i);
                cmp(int'(ch_ref_b[i*4 +: 4]), rb, pos ? "R6" : "R7", i);
            end
        end
    end

    task automatic tick(input bit ld, input bit pol, input logic [NCH*6-1:0] bus);
        @(negedge clk);
        ld_strobe = ld;
        pol_sel   = pol;
        line_bus  = bus;
    endtask

    function automatic logic [NCH*6-1:0] ramp(input int base, input int stride);
        logic [NCH*6-1:0] v;
        for (int i = 0; i < NCH; i++) v[i*6 +: 6] = 6'((base + i * stride) % 64);
        return v;
    endfunction

    initial begin
        logic [NCH*6-1:0] corners;
        // Reset (R1): bus and pol busy during reset must not land
        phase = "R1";
        repeat (3) tick(1'b1, 1'b1, ramp(7, 5));
        check_en = 1'b1;
        tick(1'b0, 1'b0, '0);
        rst_n = 1'b1;
        tick(1'b0, 1'b1, ramp(3, 9));
        tick(1'b0, 1'b1, ramp(3, 9));

        // Basic load with pol 1 (R2, R5, R6, R7, R8)
        phase = "R2";
        tick(1'b1, 1'b1, ramp(0, 5));
        tick(1'b0, 1'b0, ramp(1, 1));

        // Corner codes on both chains (R6, R7, R9)
        phase = "R9";
        corners = '0;
        corners[0*6 +: 6] = 6'h00; corners[1*6 +: 6] = 6'h00;
        corners[2*6 +: 6] = 6'h0F; corners[3*6 +: 6] = 6'h10;
        corners[4*6 +: 6] = 6'h1F; corners[5*6 +: 6] = 6'h20;
        corners[6*6 +: 6] = 6'h2F; corners[7*6 +: 6] = 6'h30;
        corners[8*6 +: 6] = 6'h3F; corners[9*6 +: 6] = 6'h3F;
        corners[10*6 +: 6] = 6'h0F; corners[11*6 +: 6] = 6'h2F;
        tick(1'b1, 1'b0, corners);
        tick(1'b0, 1'b1, corners);
        tick(1'b1, 1'b1, corners);
        tick(1'b0, 1'b0, '0);

        // Strobe held high while bus and pol keep moving (R3, R4)
        phase = "R3";
        tick(1'b1, 1'b0, ramp(11, 7));
        for (int k = 0; k < 6; k++) tick(1'b1, k[0], ramp(20 + k, 3));
        phase = "R4";
        for (int k = 0; k < 6; k++) tick(1'b0, ~k[0], ramp(40 + k, 13));

        // Alternate-cycle loads with partly rewritten latch (R10)
        phase = "R10";
        for (int k = 0; k < 10; k++) begin
            logic [NCH*6-1:0] b;
            b = ramp(k * 4, 1);
            b[(k % NCH)*6 +: 6] = 6'h3F;
            tick(k[0] == 1'b0, k[1], b);
        end

        // Random traffic
        phase = "RND";
        for (int k = 0; k < 300; k++) begin
            logic [NCH*6-1:0] b;
            for (int i = 0; i < NCH; i++) b[i*6 +: 6] = 6'($urandom_range(0, 63));
            tick(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), b);
        end

        // Mid-run reset, strobe high across release (R1, R2)
        phase = "R1";
        tick(1'b1, 1'b1, ramp(5, 2));
        rst_n = 1'b0;
        tick(1'b1, 1'b1, ramp(5, 2));
        tick(1'b1, 1'b1, ramp(9, 2));
        rst_n = 1'b1;
        phase = "R2";
        tick(1'b1, 1'b0, ramp(9, 2));
        tick(1'b0, 1'b0, ramp(9, 2));
        tick(1'b0, 1'b0, ramp(9, 2));

        @(negedge clk);
        check_en = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule